// File: doc/BRIEF.md
# Predicted branch resolution tracker

This block tracks every predicted conditional branch still in flight and checks each prediction against the real outcome. A decoder hands it at most one branch per cycle. Each branch carries a tag, a predicted direction, a flag that marks it integer or floating-point, and, for a floating-point branch, the index of the condition code it reads. The tracker keeps the branches in age order in a small queue.

Integer outcomes come back through a single ALU port, which carries a tag and a direction. Floating-point outcomes come from condition-code writes. One write settles every waiting floating-point branch that reads that code in the same cycle. An integer outcome arriving in that cycle can settle one more branch alongside them.

A branch whose prediction was right becomes ready to graduate, and graduating branches leave the oldest end in order through a valid/ready stream. A wrong prediction discards that branch and every younger one, and emits a one-cycle redirect that carries the branch's tag and its true direction. The decode stream follows valid/ready rules. `dec_ready` depends only on how full the queue is. A branch is taken in on a cycle where `dec_valid` and `dec_ready` are both high, and the decoder keeps its branch steady while `dec_ready` is low. The graduation stream holds `grad_valid` and `grad_tag` until the consumer raises `grad_ready`.

Top module: `branch_resolve_tracker`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `dec_ready` is 1, and `grad_valid` and `redirect_valid` are 0.
- R2: At most one branch enters per cycle, and only when `dec_valid` and `dec_ready` are both high. `dec_ready` is 0 exactly while DEPTH (default 4) branches are held, and a branch offered while full is not taken in.
- R3: An ALU outcome whose `alu_tag` equals the tag of a waiting integer branch resolves that branch. If `alu_taken` equals the predicted direction, the branch becomes ready to graduate.
- R4: A condition-code write resolves every waiting floating-point branch whose `dec_cc` index equals `cc_idx`. The actual direction is taken when `cc_value` is 1 and not taken when it is 0.
- R5: A single condition-code write resolves all branches that depend on it in the same cycle. An ALU outcome in that cycle resolves its integer branch too, so up to four branches can resolve at one clock edge.
- R6: A misprediction raises `redirect_valid` for one cycle, starting in the cycle after the outcome is presented. In that cycle `redirect_tag` holds the branch's tag and `redirect_taken` holds its actual direction.
- R7: When several branches mispredict at the same edge, the redirect names the oldest of them.
- R8: At a misprediction the mispredicted branch and all younger ones are removed and older ones are kept. A branch offered on the decode port in that same cycle is dropped.
- R9: `grad_valid` is high only while the oldest held branch is resolved correct, with `grad_tag` showing its tag. A younger resolved branch never graduates before an older unresolved one. `grad_valid` and `grad_tag` stay steady until `grad_ready` takes the branch, at most one per cycle.
- R10: Some outcomes have no effect, and branch state and outputs stay unchanged after them. These are an ALU outcome whose tag matches no waiting integer branch, including one that matches a floating-point branch; a condition-code write with no waiting dependents; and a second outcome for an already resolved branch.
- R11: A correctly resolved oldest branch shows `grad_valid` in the cycle right after its outcome is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | A decoded branch is offered |
| dec_ready | output | 1 | The tracker has a free entry |
| dec_is_fp | input | 1 | 1 = floating-point branch, 0 = integer branch |
| dec_pred_taken | input | 1 | Predicted direction, 1 = taken |
| dec_cc | input | 2 | Condition-code index that a floating-point branch reads |
| dec_tag | input | 4 | Branch tag, unique among branches in flight |
| alu_valid | input | 1 | Integer outcome strobe |
| alu_tag | input | 4 | Tag of the resolved integer branch |
| alu_taken | input | 1 | Actual integer direction, 1 = taken |
| cc_valid | input | 1 | Condition-code write strobe |
| cc_idx | input | 2 | Index of the written condition code |
| cc_value | input | 1 | Written value, 1 = branch taken |
| grad_valid | output | 1 | Oldest branch is ready to graduate |
| grad_ready | input | 1 | Graduation consumer takes the branch |
| grad_tag | output | 4 | Tag of the graduating branch |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_tag | output | 4 | Tag of the mispredicted branch |
| redirect_taken | output | 1 | Actual direction to fetch along |

## Verification
A lost or stale done bit shows up at the ports in the cycle after the outcome. Either `grad_valid` fails to rise there, or it rises for a branch that was never resolved. A wrong age order or a bad truncation point appears as a wrong `grad_tag` at the next pop, or as a removed branch that later graduates. An error in the mispredict priority is seen one cycle after the outcome, as a wrong `redirect_tag` or `redirect_taken`. A wrong occupancy count shows up at once as a `dec_ready` that drops too early or too late.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int TAG_W = 4;
  localparam int CC_W  = 2;

  typedef struct packed {
    logic             is_fp;
    logic             pred;
    logic [CC_W-1:0]  cc;
    logic [TAG_W-1:0] tag;
    logic             done;
  } br_entry_t;
endpackage

// File: rtl/brt_resolve.sv
// Per-entry outcome matching: integer via ALU tag, floating-point via cc index.
module brt_resolve
  import brt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  br_entry_t [DEPTH-1:0] ent,
  input  logic [CNT_W-1:0]      occ,
  input  logic                  alu_valid,
  input  logic [TAG_W-1:0]      alu_tag,
  input  logic                  alu_taken,
  input  logic                  cc_valid,
  input  logic [CC_W-1:0]       cc_idx,
  input  logic                  cc_value,
  output logic [DEPTH-1:0]      hit,
  output logic [DEPTH-1:0]      mis,
  output logic [DEPTH-1:0]      actual
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic live, int_hit, fp_hit;
    assign live    = (CNT_W'(i) < occ) && !ent[i].done;
    assign int_hit = live && !ent[i].is_fp && alu_valid && (alu_tag == ent[i].tag);
    assign fp_hit  = live && ent[i].is_fp && cc_valid && (cc_idx == ent[i].cc);
    assign hit[i]    = int_hit | fp_hit;
    assign actual[i] = int_hit ? alu_taken : cc_value;
    assign mis[i]    = hit[i] && (actual[i] != ent[i].pred);
  end
endmodule

// File: rtl/brt_oldest.sv
// Picks the lowest (oldest) index with a misprediction.
module brt_oldest #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] mis,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mis[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/brt_queue.sv
// Age-ordered storage: slot 0 is oldest; pops shift down, flushes truncate.
module brt_queue
  import brt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  br_entry_t             push_ent,
  input  logic                  pop,
  input  logic [DEPTH-1:0]      hit,
  input  logic                  flush,
  input  logic [IDX_W-1:0]      flush_idx,
  output br_entry_t [DEPTH-1:0] ent_q,
  output logic [CNT_W-1:0]      occ_q
);
  br_entry_t [DEPTH:0]   ext;
  br_entry_t [DEPTH-1:0] ent_d;
  logic [CNT_W-1:0]      occ_d;
  int                    keep;

  always_comb begin
    ext[DEPTH] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ext[i]      = ent_q[i];
      ext[i].done = ent_q[i].done | hit[i];
    end
    keep = (flush ? int'(flush_idx) : int'(occ_q)) - (pop ? 1 : 0);
    for (int j = 0; j < DEPTH; j++) begin
      if (j < keep)
        ent_d[j] = pop ? ext[j+1] : ext[j];
      else if (push && !flush && j == keep)
        ent_d[j] = push_ent;
      else
        ent_d[j] = '0;
    end
    occ_d = CNT_W'(keep + ((push && !flush) ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
      occ_q <= '0;
    end else begin
      ent_q <= ent_d;
      occ_q <= occ_d;
    end
  end
endmodule

// File: rtl/branch_resolve_tracker.sv
module branch_resolve_tracker
  import brt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  output logic             dec_ready,
  input  logic             dec_is_fp,
  input  logic             dec_pred_taken,
  input  logic [CC_W-1:0]  dec_cc,
  input  logic [TAG_W-1:0] dec_tag,
  input  logic             alu_valid,
  input  logic [TAG_W-1:0] alu_tag,
  input  logic             alu_taken,
  input  logic             cc_valid,
  input  logic [CC_W-1:0]  cc_idx,
  input  logic             cc_value,
  output logic             grad_valid,
  input  logic             grad_ready,
  output logic [TAG_W-1:0] grad_tag,
  output logic             redirect_valid,
  output logic [TAG_W-1:0] redirect_tag,
  output logic             redirect_taken
);
  br_entry_t [DEPTH-1:0] ent;
  logic [CNT_W-1:0]      occ;
  logic [DEPTH-1:0]      hit, mis, actual;
  logic                  flush;
  logic [IDX_W-1:0]      flush_idx;
  logic                  push, pop;
  br_entry_t             push_ent;

  assign dec_ready  = (occ < CNT_W'(DEPTH));
  assign push       = dec_valid && dec_ready;
  assign grad_valid = (occ != '0) && ent[0].done;
  assign grad_tag   = ent[0].tag;
  assign pop        = grad_valid && grad_ready;

  always_comb begin
    push_ent       = '0;
    push_ent.is_fp = dec_is_fp;
    push_ent.pred  = dec_pred_taken;
    push_ent.cc    = dec_is_fp ? dec_cc : '0;
    push_ent.tag   = dec_tag;
  end

  brt_resolve #(.DEPTH(DEPTH)) u_resolve (
    .ent(ent), .occ(occ),
    .alu_valid(alu_valid), .alu_tag(alu_tag), .alu_taken(alu_taken),
    .cc_valid(cc_valid), .cc_idx(cc_idx), .cc_value(cc_value),
    .hit(hit), .mis(mis), .actual(actual)
  );

  brt_oldest #(.DEPTH(DEPTH)) u_oldest (
    .mis(mis), .any(flush), .idx(flush_idx)
  );

  brt_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ent(push_ent), .pop(pop),
    .hit(hit), .flush(flush), .flush_idx(flush_idx),
    .ent_q(ent), .occ_q(occ)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_tag   <= '0;
      redirect_taken <= 1'b0;
    end else begin
      redirect_valid <= flush;
      if (flush) begin
        redirect_tag   <= ent[flush_idx].tag;
        redirect_taken <= actual[flush_idx];
      end
    end
  end
endmodule

// File: rtl/branch_resolve_tracker_chk.sv
module branch_resolve_tracker_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_ready,
  input logic             grad_valid,
  input logic             grad_ready,
  input logic [TAG_W-1:0] grad_tag,
  input logic             redirect_valid,
  input logic             alu_valid,
  input logic             cc_valid,
  input logic [CNT_W-1:0] occ
);
  assert_full_blocks_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !dec_ready);
  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  assert_grad_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grad_valid |-> (occ != '0));
  assert_grad_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grad_valid && !grad_ready) |=> (grad_valid && $stable(grad_tag)));
  assert_redirect_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect_valid) |-> $past(alu_valid || cc_valid));
  assert_flush_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && $past(rst_n)) |-> (occ <= $past(occ)));
endmodule

bind branch_resolve_tracker branch_resolve_tracker_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .TAG_W(brt_pkg::TAG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .dec_ready(dec_ready),
  .grad_valid(grad_valid), .grad_ready(grad_ready), .grad_tag(grad_tag),
  .redirect_valid(redirect_valid), .alu_valid(alu_valid),
  .cc_valid(cc_valid), .occ(occ)
);

// File: tb/branch_resolve_tracker_tb_top.sv
module branch_resolve_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 0, dec_is_fp = 0, dec_pred_taken = 0;
  logic [1:0] dec_cc = 0;
  logic [3:0] dec_tag = 0;
  logic       alu_valid = 0, alu_taken = 0;
  logic [3:0] alu_tag = 0;
  logic       cc_valid = 0, cc_value = 0;
  logic [1:0] cc_idx = 0;
  logic       grad_ready = 0;
  logic       dec_ready, grad_valid, redirect_valid, redirect_taken;
  logic [3:0] grad_tag, redirect_tag;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  branch_resolve_tracker dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    dec_valid = 0; alu_valid = 0; cc_valid = 0; grad_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic push(int tag, bit fp, bit pred, int cc);
    dec_valid = 1; dec_tag = 4'(tag); dec_is_fp = fp;
    dec_pred_taken = pred; dec_cc = 2'(cc);
    tick();
  endtask

  task automatic alu(int tag, bit taken);
    alu_valid = 1; alu_tag = 4'(tag); alu_taken = taken;
    tick();
  endtask

  task automatic ccw(int idx, bit val);
    cc_valid = 1; cc_idx = 2'(idx); cc_value = val;
    tick();
  endtask

  task automatic pop();
    grad_ready = 1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 dec_ready", dec_ready, 1);
    check("R1 grad_valid", grad_valid, 0);
    check("R1 redirect_valid", redirect_valid, 0);
  endtask

  task automatic t_int_correct();
    do_reset();
    push(5, 0, 1, 0);
    check("R11 grad_valid before outcome", grad_valid, 0);
    alu(5, 1);
    check("R11 grad_valid after outcome", grad_valid, 1);
    check("R3 grad_tag", grad_tag, 5);
    check("R3 no redirect", redirect_valid, 0);
    tick();
    check("R9 held valid", grad_valid, 1);
    check("R9 held tag", grad_tag, 5);
    pop();
    check("R9 popped", grad_valid, 0);
  endtask

  task automatic t_fill_order();
    do_reset();
    for (int i = 0; i < 4; i++) push(i, 0, 1, 0);
    check("R2 full not ready", dec_ready, 0);
    push(12, 0, 1, 0);
    alu(3, 1);
    check("R9 younger waits", grad_valid, 0);
    alu(1, 1);
    alu(2, 1);
    alu(12, 1);
    check("R9 still waits", grad_valid, 0);
    alu(0, 1);
    check("R9 head valid", grad_valid, 1);
    check("R9 head tag", grad_tag, 0);
    for (int i = 1; i < 4; i++) begin
      pop();
      check("R9 in-order valid", grad_valid, 1);
      check("R9 in-order tag", grad_tag, i);
    end
    pop();
    check("R2 fifth not accepted", grad_valid, 0);
    check("R2 ready again", dec_ready, 1);
  endtask

  task automatic t_fp_multi();
    do_reset();
    push(1, 1, 1, 2);
    push(2, 0, 0, 0);
    push(3, 1, 1, 2);
    push(4, 1, 1, 1);
    cc_valid = 1; cc_idx = 2; cc_value = 1;
    alu_valid = 1; alu_tag = 2; alu_taken = 0;
    tick();
    check("R5 no redirect", redirect_valid, 0);
    check("R5 grad first", grad_tag, 1);
    check("R5 grad valid", grad_valid, 1);
    pop();
    check("R5 second resolved", grad_valid, 1);
    check("R5 second tag", grad_tag, 2);
    pop();
    check("R5 third resolved", grad_valid, 1);
    check("R5 third tag", grad_tag, 3);
    pop();
    check("R4 other cc pending", grad_valid, 0);
    ccw(1, 0);
    check("R6 redirect", redirect_valid, 1);
    check("R4 redirect tag", redirect_tag, 4);
    check("R4 redirect dir", redirect_taken, 0);
    tick();
    check("R6 single pulse", redirect_valid, 0);
  endtask

  task automatic t_oldest_wins();
    do_reset();
    push(1, 0, 0, 0);
    push(2, 1, 1, 0);
    push(3, 1, 0, 0);
    alu_valid = 1; alu_tag = 1; alu_taken = 1;
    cc_valid = 1; cc_idx = 0; cc_value = 0;
    dec_valid = 1; dec_tag = 9; dec_is_fp = 0; dec_pred_taken = 1;
    tick();
    check("R7 redirect", redirect_valid, 1);
    check("R7 oldest tag", redirect_tag, 1);
    check("R7 dir", redirect_taken, 1);
    check("R8 emptied", grad_valid, 0);
    alu(9, 1);
    check("R8 decode dropped", grad_valid, 0);
    ccw(0, 1);
    check("R8 younger gone grad", grad_valid, 0);
    check("R8 younger gone redirect", redirect_valid, 0);
    push(6, 0, 0, 0);
    alu(6, 0);
    check("R8 fresh head valid", grad_valid, 1);
    check("R8 fresh head tag", grad_tag, 6);
  endtask

  task automatic t_partial_flush();
    do_reset();
    push(1, 0, 1, 0);
    push(2, 0, 1, 0);
    push(3, 0, 0, 0);
    alu(2, 0);
    check("R6 redirect", redirect_valid, 1);
    check("R6 tag", redirect_tag, 2);
    check("R6 dir", redirect_taken, 0);
    alu(1, 1);
    check("R8 older kept", grad_valid, 1);
    check("R8 older tag", grad_tag, 1);
    pop();
    check("R8 only one kept", grad_valid, 0);
    alu(3, 1);
    check("R8 removed entry silent", redirect_valid, 0);
    check("R8 removed no grad", grad_valid, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    push(6, 0, 1, 0);
    push(8, 1, 1, 0);
    alu(7, 0);
    check("R10 unknown tag redirect", redirect_valid, 0);
    check("R10 unknown tag grad", grad_valid, 0);
    alu(8, 0);
    check("R10 fp via alu redirect", redirect_valid, 0);
    check("R10 fp via alu grad", grad_valid, 0);
    ccw(3, 0);
    check("R10 cc no dependents", redirect_valid, 0);
    alu(6, 1);
    check("R3 resolved", grad_valid, 1);
    check("R3 tag", grad_tag, 6);
    alu(6, 0);
    check("R10 repeat outcome", redirect_valid, 0);
    check("R10 repeat keeps head", grad_tag, 6);
    cc_valid = 1; cc_idx = 0; cc_value = 1;
    pop();
    check("R4 fp taken resolved", grad_valid, 1);
    check("R4 fp tag", grad_tag, 8);
    check("R4 fp no redirect", redirect_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_int_correct();
    t_fill_order();
    t_fp_multi();
    t_oldest_wins();
    t_partial_flush();
    t_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule